// File: doc/BRIEF.md
# Register-Operand Data-Processing Execute Unit

This block executes one register-operand data-processing instruction per cycle for a 64-bit load/store core. It decodes the 32-bit instruction word and takes the values of up to three source registers from the surrounding register file. Operand 2 passes through a shifter that can apply logical left, logical right, arithmetic right or rotate right, and it may then be bitwise inverted. The unit then produces an arithmetic, logical or multiply-accumulate result at 32-bit or 64-bit width.

The result, the destination index and a write enable are registered and appear one cycle after `valid_i`. The condition flags are held inside the block and are updated only by the flag-setting variants. An instruction word that breaks the encoding rules produces a one-cycle `illegal_o` pulse. Such a word causes no register write and no flag change. The register file itself, memory access and branching sit outside this unit.

Top module: `reg_alu`

## Requirements
- R1: A word belongs to this class only when bits 27:25 equal 101. Any other word sets `illegal_o` one cycle later and causes no write. The fields are: bit 31 width (1 = 64-bit), bits 30:29 operation code, bit 28 multiply select, bit 24 arithmetic (1) or logic (0), bits 23:22 shift kind, bit 21 invert, bits 20:16 second source, bits 15:10 shift amount, bits 9:5 first source and bits 4:0 destination.
- R2: Register index 31 reads as zero for the first source, the second source and the accumulator. A destination of 31 never asserts `wr_en_o`, but flags are still updated.
- R3: Operand 2 is shifted by bits 15:10 with kind LSL=0, LSR=1, ASR=2 or ROR=3. ASR replicates the sign bit of the active width. ROR rotates within the active width, and a rotate by 0 leaves the value unchanged.
- R4: Bit 21 inverts the shifted operand 2. An arithmetic instruction that has bit 21 set or uses ROR is illegal.
- R5: The arithmetic codes are ADD=0, ADDS=1, SUB=2 and SUBS=3. ADDS sets N from the result sign, Z when the result is zero, C from the unsigned carry out of the active width, and V on signed overflow.
- R6: SUBS sets C when the first operand is at least the second (unsigned). It sets V when the operand signs differ and the result sign differs from the sign of the first operand.
- R7: The logic codes are AND=0, OR=1, XOR=2 and flag-setting AND=3. Flag-setting AND sets N and Z from the result and clears C and V.
- R8: Bit 28 = 1 selects multiply-accumulate. It is legal only with code 0, bit 24 = 1, shift kind 0 and bit 21 = 0. Bits 14:10 name the accumulator. The result is accumulator + product, or accumulator − product when bit 15 is 1.
- R9: In 32-bit mode the operands are taken from their low 32 bits and the result is zero-extended to 64 bits. A non-multiply shift amount of 32 or more is illegal.
- R10: The flags reset to N=0, Z=1, C=0, V=0, reported as `flags_o` = {N,Z,C,V}. ADD, SUB, AND, OR, XOR, multiply, illegal words and idle cycles leave the flags unchanged.
- R11: Outputs are registered. `valid_o` follows `valid_i` by one cycle, and `wr_en_o` is low on any cycle where `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word present this cycle |
| ins_i | input | 32 | Instruction word |
| rn_val_i | input | 64 | Value of the first source register |
| rm_val_i | input | 64 | Value of the second source register |
| ra_val_i | input | 64 | Value of the accumulator register |
| valid_o | output | 1 | A result from the previous cycle is present |
| wr_en_o | output | 1 | Write the result to the destination |
| wr_idx_o | output | 5 | Destination register index |
| result_o | output | 64 | Result, zero-extended in 32-bit mode |
| flags_o | output | 4 | Current flags {N,Z,C,V} |
| illegal_o | output | 1 | The previous word was rejected |

## Verification
The bench focuses on flag edge cases. It covers signed overflow that yields a negative 32-bit result, an unsigned borrow in SUBS, and the flag-setting AND clearing a C and V that were set before it. A design that got these wrong would leave stale carry or overflow bits or compute them at the wrong width. It checks ASR at both widths and ROR in 32-bit mode, where a shifter that ignored the active width would leak upper-half bits into the result. Register 31 is tested as a source and as a destination. Each illegal form is tested: inverted arithmetic, arithmetic ROR, an oversized 32-bit shift, a malformed multiply and a foreign class. In every one of these the flags must stay unchanged, which catches a design that lets a rejected word write or update state.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {SH_LSL = 2'd0, SH_LSR = 2'd1, SH_ASR = 2'd2, SH_ROR = 2'd3} shift_e;
  typedef enum logic [1:0] {K_ARITH = 2'd0, K_LOGIC = 2'd1, K_MUL = 2'd2} kind_e;

  localparam logic [4:0] ZERO_REG = 5'd31;

  typedef struct packed {
    logic       narrow;
    logic [1:0] opc;
    kind_e      kind;
    shift_e     sh;
    logic       inv;
    logic [5:0] amt;
    logic [4:0] rd;
    logic [4:0] rn;
    logic [4:0] rm;
    logic [4:0] ra;
    logic       msub;
    logic       illegal;
    logic       flag_set;
  } dec_t;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [31:0] ins_i,
  output dec_t        dec_o
);
  always_comb begin
    dec_o.narrow = ~ins_i[31];
    dec_o.opc    = ins_i[30:29];
    dec_o.kind   = ins_i[28] ? K_MUL : (ins_i[24] ? K_ARITH : K_LOGIC);
    dec_o.sh     = shift_e'(ins_i[23:22]);
    dec_o.inv    = ins_i[21];
    dec_o.rm     = ins_i[20:16];
    dec_o.amt    = ins_i[15:10];
    dec_o.rn     = ins_i[9:5];
    dec_o.rd     = ins_i[4:0];
    dec_o.ra     = ins_i[14:10];
    dec_o.msub   = ins_i[15];
    dec_o.illegal =
        (ins_i[27:25] != 3'b101)
      | (dec_o.narrow & dec_o.amt[5] & (dec_o.kind != K_MUL))
      | ((dec_o.kind == K_ARITH) & (dec_o.inv | (dec_o.sh == SH_ROR)))
      | ((dec_o.kind == K_MUL) & ((dec_o.opc != 2'd0) | ~ins_i[24]
                                  | (dec_o.sh != SH_LSL) | dec_o.inv));
    dec_o.flag_set = ((dec_o.kind == K_ARITH) & dec_o.opc[0])
                   | ((dec_o.kind == K_LOGIC) & (dec_o.opc == 2'd3));
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int HALF_W = DATA_W / 2,
  localparam int SH_W   = $clog2(DATA_W)
) (
  input  logic              narrow_i,
  input  shift_e            sh_i,
  input  logic              inv_i,
  input  logic [SH_W-1:0]   amt_i,
  input  logic [DATA_W-1:0] op_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0]   mask, opm, sext, shv;
  logic [2*DATA_W-1:0] rot_w;
  logic [DATA_W-1:0]   rot_n;

  always_comb begin
    mask  = narrow_i ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : {DATA_W{1'b1}};
    opm   = op_i & mask;
    sext  = narrow_i ? {{HALF_W{op_i[HALF_W-1]}}, op_i[HALF_W-1:0]} : op_i;
    rot_w = {opm, opm} >> amt_i;
    rot_n = {opm[HALF_W-1:0], opm[HALF_W-1:0]} >> amt_i;
    unique case (sh_i)
      SH_LSL:  shv = opm << amt_i;
      SH_LSR:  shv = opm >> amt_i;
      SH_ASR:  shv = $unsigned($signed(sext) >>> amt_i);
      default: shv = narrow_i ? rot_n : rot_w[DATA_W-1:0];
    endcase
    res_o = (inv_i ? ~shv : shv) & mask;
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              narrow_i,
  input  kind_e             kind_i,
  input  logic [1:0]        opc_i,
  input  logic              msub_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] m_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic [DATA_W-1:0] res_o,
  output logic [3:0]        nzcv_o
);
  logic [DATA_W-1:0] mask, am, mm, accm, prod, raw;
  logic [DATA_W:0]   sum;
  logic              sa, sb, sr, c, v;

  always_comb begin
    mask = narrow_i ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : {DATA_W{1'b1}};
    am   = a_i & mask;
    mm   = m_i & mask;
    accm = acc_i & mask;
    prod = am * mm;
    sum  = {1'b0, am} + {1'b0, b_i};
    c = 1'b0;
    v = 1'b0;
    sa = narrow_i ? am[HALF_W-1] : am[DATA_W-1];
    sb = narrow_i ? b_i[HALF_W-1] : b_i[DATA_W-1];
    unique case (kind_i)
      K_ARITH: raw = opc_i[1] ? am - b_i : sum[DATA_W-1:0];
      K_LOGIC: begin
        unique case (opc_i)
          2'd1:    raw = am | b_i;
          2'd2:    raw = am ^ b_i;
          default: raw = am & b_i;
        endcase
      end
      default: raw = msub_i ? accm - prod : accm + prod;
    endcase
    res_o = raw & mask;
    sr = narrow_i ? res_o[HALF_W-1] : res_o[DATA_W-1];
    if (kind_i == K_ARITH) begin
      if (opc_i[1]) begin
        c = (am >= b_i);
        v = (sa != sb) & (sr != sa);
      end else begin
        c = narrow_i ? sum[HALF_W] : sum[DATA_W];
        v = (sa == sb) & (sr != sa);
      end
    end
    nzcv_o = {sr, (res_o == '0), c, v};
  end
endmodule

// File: rtl/reg_alu.sv
module reg_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       ins_i,
  input  logic [DATA_W-1:0] rn_val_i,
  input  logic [DATA_W-1:0] rm_val_i,
  input  logic [DATA_W-1:0] ra_val_i,
  output logic              valid_o,
  output logic              wr_en_o,
  output logic [4:0]        wr_idx_o,
  output logic [DATA_W-1:0] result_o,
  output logic [3:0]        flags_o,
  output logic              illegal_o
);
  dec_t              dec;
  logic [DATA_W-1:0] rn_v, rm_v, ra_v, op2, res;
  logic [3:0]        nzcv;

  alu_decode i_dec (.ins_i(ins_i), .dec_o(dec));

  // index 31 is the zero register on every read port
  assign rn_v = (dec.rn == ZERO_REG) ? '0 : rn_val_i;
  assign rm_v = (dec.rm == ZERO_REG) ? '0 : rm_val_i;
  assign ra_v = (dec.ra == ZERO_REG) ? '0 : ra_val_i;

  alu_shifter #(.DATA_W(DATA_W)) i_shf (
    .narrow_i(dec.narrow), .sh_i(dec.sh), .inv_i(dec.inv),
    .amt_i(dec.amt[SH_W-1:0]), .op_i(rm_v), .res_o(op2)
  );

  alu_core #(.DATA_W(DATA_W)) i_core (
    .narrow_i(dec.narrow), .kind_i(dec.kind), .opc_i(dec.opc), .msub_i(dec.msub),
    .a_i(rn_v), .b_i(op2), .m_i(rm_v), .acc_i(ra_v), .res_o(res), .nzcv_o(nzcv)
  );

  logic take;
  assign take = valid_i & ~dec.illegal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      result_o  <= '0;
      flags_o   <= 4'b0100;
      illegal_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      illegal_o <= valid_i & dec.illegal;
      wr_en_o   <= take & (dec.rd != ZERO_REG);
      if (take) begin
        wr_idx_o <= dec.rd;
        result_o <= res;
        if (dec.flag_set) flags_o <= nzcv;
      end
    end
  end
endmodule

// File: rtl/reg_alu_chk.sv
module reg_alu_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [7:0]        ins_hi_i,
  input logic              valid_o,
  input logic              wr_en_o,
  input logic [4:0]        wr_idx_o,
  input logic [DATA_W-1:0] result_o,
  input logic [3:0]        flags_o,
  input logic              illegal_o
);
  localparam int HALF_W = DATA_W / 2;
  logic vin_q, narrow_q, ands_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vin_q <= 1'b0; narrow_q <= 1'b0; ands_q <= 1'b0;
    end else begin
      vin_q    <= valid_i;
      narrow_q <= valid_i & ~ins_hi_i[7];
      ands_q   <= valid_i & (ins_hi_i[6:5] == 2'd3) & ~ins_hi_i[4]
                & (ins_hi_i[3:1] == 3'b101) & ~ins_hi_i[0];
    end
  end

  // R2
  zero_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_idx_o != 5'd31);
  // R1
  illegal_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wr_en_o && valid_o));
  // R10
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(flags_o) |-> (valid_o && !illegal_o));
  // R11
  valid_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> vin_q);
  // R11
  wr_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> valid_o);
  // R9
  zero_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (narrow_q && wr_en_o) |-> result_o[DATA_W-1:HALF_W] == '0);
  // R7
  ands_cv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ands_q && valid_o && !illegal_o) |-> flags_o[1:0] == 2'b00);
endmodule

bind reg_alu reg_alu_chk #(.DATA_W(DATA_W)) i_reg_alu_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ins_hi_i(ins_i[31:24]),
  .valid_o(valid_o), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .result_o(result_o),
  .flags_o(flags_o), .illegal_o(illegal_o)
);

// File: tb/test_reg_alu.sv
`timescale 1ns/1ps
module test_reg_alu;
  localparam int N = 16;
  logic        clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic [31:0] ins_i = '0;
  logic [63:0] rn_val_i = '0, rm_val_i = '0, ra_val_i = '0;
  logic        valid_o, wr_en_o, illegal_o;
  logic [4:0]  wr_idx_o;
  logic [63:0] result_o;
  logic [3:0]  flags_o;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  reg_alu i_reg_alu (.*);

  // columns: width, opc, mul, arith, shift, inv, amt, rn, rm, ra, result, flags
  localparam logic        T_W   [N] = '{1,1,0,1,1,1,1,1,0,0,1,1,1,1,0,1};
  localparam logic [1:0]  T_OPC [N] = '{0,1,1,3,3,2,0,1,2,0,0,3,3,0,0,1};
  localparam logic        T_MUL [N] = '{0,0,0,0,0,0,0,0,0,0,0,0,0,1,1,0};
  localparam logic        T_AR  [N] = '{1,1,1,1,1,1,0,0,0,1,1,0,0,1,1,0};
  localparam logic [1:0]  T_SH  [N] = '{0,0,0,0,0,0,1,0,3,2,2,0,0,0,0,3};
  localparam logic        T_INV [N] = '{0,0,0,0,0,0,0,1,0,0,0,0,0,0,0,0};
  localparam logic [5:0]  T_AMT [N] = '{0,0,0,0,0,4,8,0,8,4,60,0,0,6'h04,6'h24,0};
  localparam logic [63:0] T_RN  [N] = '{64'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'hABCD_0000_7FFF_FFFF,
    64'd3, 64'h8000_0000_0000_0000, 64'h100, 64'hFFFF, 64'd0, 64'd0, 64'd0, 64'd0,
    64'hF0, 64'h8000_0000_0000_0000, 64'd6, 64'd3, 64'd0};
  localparam logic [63:0] T_RM  [N] = '{64'd7, 64'd1, 64'd1, 64'd5, 64'd1, 64'd3, 64'hAB00,
    64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_1234_5678, 64'h8000_0000, 64'h8000_0000_0000_0000,
    64'h0F, 64'hFFFF_FFFF_FFFF_FFFF, 64'd7, 64'd5, 64'h1234};
  localparam logic [63:0] T_RA  [N] = '{64'd0, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0,
    64'd0, 64'd0, 64'd0, 64'd0, 64'd0, 64'd100, 64'd10, 64'd0};
  localparam logic [63:0] T_RES [N] = '{64'd12, 64'd0, 64'h8000_0000, 64'hFFFF_FFFF_FFFF_FFFE,
    64'h7FFF_FFFF_FFFF_FFFF, 64'hD0, 64'hAB, 64'h0000_0000_FFFF_FFFF, 64'h7812_3456,
    64'hF800_0000, 64'hFFFF_FFFF_FFFF_FFF8, 64'd0, 64'h8000_0000_0000_0000, 64'h8E,
    64'hFFFF_FFFB, 64'h1234};
  localparam logic [3:0]  T_FLG [N] = '{4'b0100, 4'b0110, 4'b1001, 4'b1000, 4'b0011, 4'b0011,
    4'b0011, 4'b0011, 4'b0011, 4'b0011, 4'b0011, 4'b0100, 4'b1000, 4'b1000, 4'b1000, 4'b1000};
  localparam string T_REQ [N] = '{"R5", "R5", "R9", "R6", "R6", "R3", "R3", "R4", "R3",
    "R3", "R3", "R7", "R7", "R8", "R8", "R3"};

  function automatic logic [31:0] enc(logic w, logic [1:0] opc, logic mul, logic ar,
      logic [1:0] sh, logic inv, logic [4:0] rm, logic [5:0] amt, logic [4:0] rn, logic [4:0] rd);
    return {w, opc, mul, 3'b101, ar, sh, inv, rm, amt, rn, rd};
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(logic [31:0] ins, logic [63:0] rn, logic [63:0] rm, logic [63:0] ra);
    @(negedge clk_i);
    valid_i = 1'b1; ins_i = ins; rn_val_i = rn; rm_val_i = rm; ra_val_i = ra;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10 reset flags", 64'(flags_o), 64'h4);
    check("R11 reset valid", 64'(valid_o), 64'h0);
    check("R11 reset wr_en", 64'(wr_en_o), 64'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < N; i++) begin
      issue(enc(T_W[i], T_OPC[i], T_MUL[i], T_AR[i], T_SH[i], T_INV[i], 5'd2, T_AMT[i], 5'd1, 5'd3),
            T_RN[i], T_RM[i], T_RA[i]);
      check(T_REQ[i], result_o, T_RES[i]);
      check({T_REQ[i], " flags"}, 64'(flags_o), 64'(T_FLG[i]));
      check("R11 write", {wr_en_o, valid_o, illegal_o, wr_idx_o}, {3'b110, 5'd3});
    end

    // R2 destination 31: flags update, no write
    issue(enc(1, 1, 0, 1, 0, 0, 5'd2, 0, 5'd1, 5'd31), 64'd2, 64'd2, 64'd0);
    check("R2 rd31 wr_en", {wr_en_o, valid_o}, 2'b01);
    check("R2 rd31 flags", 64'(flags_o), 64'h0);
    // R2 first source 31 reads zero
    issue(enc(1, 0, 0, 1, 0, 0, 5'd2, 0, 5'd31, 5'd3), 64'h55, 64'd1, 64'd0);
    check("R2 rn31", result_o, 64'd1);
    // R2 accumulator 31 reads zero
    issue(enc(1, 0, 1, 1, 0, 0, 5'd2, 6'd31, 5'd1, 5'd3), 64'd2, 64'd3, 64'd100);
    check("R2 ra31", result_o, 64'd6);
    // R4 inverted arithmetic illegal
    issue(enc(1, 1, 0, 1, 0, 1, 5'd2, 0, 5'd1, 5'd3), 64'd0, 64'd0, 64'd0);
    check("R4 inv arith", {illegal_o, wr_en_o, 4'(flags_o)}, {2'b10, 4'b0000});
    // R4 arithmetic ROR illegal
    issue(enc(1, 3, 0, 1, 3, 0, 5'd2, 1, 5'd1, 5'd3), 64'd0, 64'd0, 64'd0);
    check("R4 ror arith", {illegal_o, wr_en_o, 4'(flags_o)}, {2'b10, 4'b0000});
    // R9 narrow shift of 32 illegal
    issue(enc(0, 3, 0, 0, 0, 0, 5'd2, 6'd32, 5'd1, 5'd3), 64'd0, 64'd0, 64'd0);
    check("R9 narrow amt32", {illegal_o, wr_en_o, 4'(flags_o)}, {2'b10, 4'b0000});
    // R8 multiply with nonzero code illegal
    issue(enc(1, 1, 1, 1, 0, 0, 5'd2, 0, 5'd1, 5'd3), 64'd2, 64'd3, 64'd0);
    check("R8 bad mul", {illegal_o, wr_en_o}, 2'b10);
    // R1 foreign class word
    issue(enc(1, 0, 0, 1, 0, 0, 5'd2, 0, 5'd1, 5'd3) & ~32'h0200_0000, 64'd1, 64'd1, 64'd0);
    check("R1 class", {illegal_o, wr_en_o}, 2'b10);
    // R11 idle cycle
    @(negedge clk_i);
    check("R11 idle", {valid_o, wr_en_o, illegal_o}, 3'b000);
    check("R10 idle flags", 64'(flags_o), 64'h0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule